// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Selectable Fill Policies

This block stores sets of signed acceleration-style samples, one X, one Y and one Z value per set, each arriving as a 16-bit left-justified word on a single sample-valid strobe. A buffer of `DEPTH` slots (32 by default) keeps whole sets. A 2-bit mode input selects among four policies: pass-through with no storage, fill-and-stop, continuous overwrite, and continuous overwrite that becomes fill-and-stop once a trigger input has been seen.

A register front end drains the block through a byte-wide read port. An internal byte index walks the six bytes of the oldest set. When the index wraps past the last byte, that set is released. A burst of `6 × DEPTH` byte reads therefore empties a full buffer. The block reports how many sets it holds. It raises a watermark flag when that count reaches a programmable level, and an overrun flag when a sample set has been lost or overwritten.

Top module: `tri_axis_fifo`

## Requirements
- R1: After reset `fill_count` is 0 and `overrun` is 0.
- R2: While `fifo_en` is 0 or `mode` is 0 (pass-through), `fill_count` stays 0 and the read port shows the most recently received set. The port shows that set in the same way whenever the buffer is enabled but empty.
- R3: The byte index starts at 0 and selects X low (0), X high (1), Y low (2), Y high (3), Z low (4) and Z high (5). Each `rd_req` advances it by one. A request made at index 5 returns the index to 0 and releases the oldest stored set. Without a sample strobe, the count never grows.
- R4: In mode 1 (fill-and-stop), sets are stored until `DEPTH` are held. A further sample is then dropped and sets `overrun`. Once a sample has been dropped, no sample is stored until the buffer is flushed, even after reads free space.
- R5: In mode 2 (overwrite), a sample arriving while the buffer is full and no set is released replaces the oldest set. `fill_count` stays at `DEPTH` and `overrun` becomes 1. An overrun only follows a sample strobe.
- R6: In mode 3, the block behaves as in mode 2 until `trig` is seen high. From the next cycle on, it behaves as in mode 1 until the buffer is flushed.
- R7: `wtm` is 1 exactly when `fill_count` is greater than or equal to `wtm_level`.
- R8: A cycle in which `fifo_en` is 0, `mode` is 0, or `mode` differs from its value in the previous cycle flushes the buffer. From the following cycle, `fill_count` is 0, `overrun` is 0 and the trigger and stop history are cleared.
- R9: If a sample arrives in the same cycle that a set is released from a full buffer, both take effect. `fill_count` stays at `DEPTH` and no overrun is raised.
- R10: `rd_restart` returns the byte index to 0 without releasing a set, and takes priority over `rd_req`.
- R11: `fill_count` never exceeds `DEPTH`, and changes by at most one step upward per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Buffer enable; 0 gives pass-through and flush |
| mode | input | 2 | 0 pass-through, 1 fill-and-stop, 2 overwrite, 3 overwrite-until-trigger |
| trig | input | 1 | Trigger used in mode 3 |
| wtm_level | input | $clog2(DEPTH) | Watermark threshold |
| smp_valid | input | 1 | New sample set strobe |
| smp_x | input | 16 | X sample, left-justified two's complement |
| smp_y | input | 16 | Y sample |
| smp_z | input | 16 | Z sample |
| rd_req | input | 1 | Consume the current byte and advance the index |
| rd_restart | input | 1 | Return the byte index to X low |
| rd_data | output | 8 | Byte selected by the index |
| fill_count | output | $clog2(DEPTH+1) | Number of stored sets |
| wtm | output | 1 | Watermark reached |
| overrun | output | 1 | A set was dropped or overwritten |

## Verification
The write of a new set and the release of the oldest set can land on the same clock edge. This matters most when the buffer is full, because the released slot has to make room for the incoming sample rather than trigger an overrun. The bench fills the buffer in fill-and-stop mode and reads five bytes of the oldest set. It then raises the sixth `rd_req` together with `smp_valid` in one cycle. The outcome is judged by a count still at `DEPTH` and a clear overrun flag, and by a full drain that returns the sets in order, ending with the one written in that cycle.

// File: rtl/tri_fifo_pkg.sv
package tri_fifo_pkg;

    localparam int AXIS_W        = 16;
    localparam int BYTES_PER_SET = 6;
    localparam int IDX_W         = 3;

    typedef struct packed {
        logic [AXIS_W-1:0] z;
        logic [AXIS_W-1:0] y;
        logic [AXIS_W-1:0] x;
    } tri_sample_t;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_FILL   = 2'd1,
        MODE_STREAM = 2'd2,
        MODE_TRIG   = 2'd3
    } fifo_mode_e;

    // Byte order inside a set: X low/high, Y low/high, Z low/high
    function automatic logic [7:0] pick_byte(tri_sample_t s, logic [IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = s.x[7:0];
            3'd1:    b = s.x[15:8];
            3'd2:    b = s.y[7:0];
            3'd3:    b = s.y[15:8];
            3'd4:    b = s.z[7:0];
            default: b = s.z[15:8];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tff_store.sv
module tff_store
    import tri_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  tri_sample_t smp_in,
    input  logic        wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    output tri_sample_t slot_out,
    output tri_sample_t latest
);

    tri_sample_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= smp_in;
    end

    always_ff @(posedge clk) begin
        if (rst)            latest <= '0;
        else if (smp_valid) latest <= smp_in;
    end

    assign slot_out = mem[rd_ptr];

endmodule

// File: rtl/tff_byte_sel.sv
module tff_byte_sel
    import tri_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic             rd_restart,
    output logic [IDX_W-1:0] idx,
    output logic             pop_req
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES_PER_SET - 1);

    assign pop_req = rd_req && !rd_restart && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst || rd_restart) idx <= '0;
        else if (rd_req)       idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

endmodule

// File: rtl/tff_ctrl.sv
module tff_ctrl
    import tri_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  fifo_mode_e    mode,
    input  logic          trig,
    input  logic          push,
    input  logic          pop_req,
    output logic          wr_en,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          ovr
);

    fifo_mode_e mode_q;
    logic trig_q, stop_q;
    logic flush, full, do_pop, fill_beh, room, accept, overwrite, drop;

    always_comb begin
        flush     = !fifo_en || (mode == MODE_PASS) || (mode != mode_q);
        full      = (count == CW'(DEPTH));
        do_pop    = pop_req && (count != '0);
        fill_beh  = (mode == MODE_FILL) || ((mode == MODE_TRIG) && trig_q);
        room      = !full || do_pop;
        accept    = push && !stop_q && room;
        overwrite = push && !room && !fill_beh;
        drop      = push && !room && fill_beh;
        wr_en     = (accept || overwrite) && !flush;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_PASS;
        else     mode_q <= mode;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
            stop_q <= 1'b0;
            trig_q <= 1'b0;
        end else begin
            if (wr_en)                 wr_ptr <= wr_ptr + 1'b1;
            if (do_pop || overwrite)   rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(accept) - CW'(do_pop);
            if (overwrite || drop)     ovr    <= 1'b1;
            if (drop)                  stop_q <= 1'b1;
            if (mode == MODE_TRIG && trig) trig_q <= 1'b1;
        end
    end

endmodule

// File: rtl/tri_axis_fifo.sv
module tri_axis_fifo
    import tri_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic [1:0]    mode,
    input  logic          trig,
    input  logic [PW-1:0] wtm_level,
    input  logic          smp_valid,
    input  logic [15:0]   smp_x,
    input  logic [15:0]   smp_y,
    input  logic [15:0]   smp_z,
    input  logic          rd_req,
    input  logic          rd_restart,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] fill_count,
    output logic          wtm,
    output logic          overrun
);

    fifo_mode_e       mode_e;
    tri_sample_t      smp_in, slot_out, latest, src;
    logic             wr_en, pop_req, active;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [IDX_W-1:0] idx;

    assign mode_e = fifo_mode_e'(mode);
    assign smp_in = '{z: smp_z, y: smp_y, x: smp_x};

    tff_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .mode(mode_e), .trig(trig),
        .push(smp_valid), .pop_req(pop_req), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .rd_ptr(rd_ptr), .count(fill_count), .ovr(overrun)
    );

    tff_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in(smp_in),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .slot_out(slot_out), .latest(latest)
    );

    tff_byte_sel sel_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_restart(rd_restart),
        .idx(idx), .pop_req(pop_req)
    );

    assign active  = fifo_en && (mode_e != MODE_PASS);
    assign src     = (active && fill_count != '0) ? slot_out : latest;
    assign rd_data = pick_byte(src, idx);
    assign wtm     = (fill_count >= CW'(wtm_level));

endmodule

// File: rtl/tri_axis_fifo_chk.sv
module tri_axis_fifo_chk #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic [1:0]    mode,
    input logic          smp_valid,
    input logic [CW-1:0] fill_count,
    input logic          overrun
);

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        int'(fill_count) <= DEPTH);

    p_cnt_step_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> int'(fill_count) <= int'($past(fill_count)) + 1);

    p_disable_flush_r8: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (fill_count == '0) && !overrun);

    p_pass_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> (fill_count == '0));

    p_no_grow_r3: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> int'(fill_count) <= int'($past(fill_count)));

    p_ovr_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(smp_valid));

endmodule

bind tri_axis_fifo tri_axis_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .mode(mode),
    .smp_valid(smp_valid), .fill_count(fill_count), .overrun(overrun)
);

// File: tb/tri_axis_fifo_tb_top.sv
module tri_axis_fifo_tb_top;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        trig = 1'b0;
    logic [4:0]  wtm_level = 5'd4;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic        rd_req = 1'b0, rd_restart = 1'b0;
    logic [7:0]  rd_data;
    logic [5:0]  fill_count;
    logic        wtm, overrun;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tri_axis_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .mode(mode), .trig(trig),
        .wtm_level(wtm_level), .smp_valid(smp_valid), .smp_x(smp_x),
        .smp_y(smp_y), .smp_z(smp_z), .rd_req(rd_req), .rd_restart(rd_restart),
        .rd_data(rd_data), .fill_count(fill_count), .wtm(wtm), .overrun(overrun)
    );

    function automatic logic [15:0] fx(int n); return 16'(n * 257 + 16'h0A05); endfunction
    function automatic logic [15:0] fy(int n); return 16'(n * 263 + 16'h3311); endfunction
    function automatic logic [15:0] fz(int n); return 16'(16'hF000 - n * 131); endfunction

    function automatic logic [7:0] exp_byte(int n, int b);
        logic [47:0] w;
        w = {fz(n), fy(n), fx(n)};
        return w[b*8 +: 8];
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(int n);
        smp_valid = 1'b1; smp_x = fx(n); smp_y = fy(n); smp_z = fz(n);
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic read_slot(int n, string req);
        for (int b = 0; b < 6; b++) begin
            chk(req, "slot byte", int'(rd_data), int'(exp_byte(n, b)));
            rd_req = 1'b1;
            tick();
            rd_req = 1'b0;
        end
    endtask

    task automatic set_mode(bit en, logic [1:0] m);
        fifo_en = en; mode = m;
        tick(); tick();
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1", "count", int'(fill_count), 0);
        chk("R1", "overrun", int'(overrun), 0);
        chk("R7", "wtm at reset", int'(wtm), 0);

        // R2 disabled: latest set visible, nothing stored
        push(100);
        chk("R2", "count disabled", int'(fill_count), 0);
        read_slot(100, "R2");
        set_mode(1'b1, 2'd0);
        push(101);
        chk("R2", "count pass-through", int'(fill_count), 0);
        read_slot(101, "R2");

        // R4/R7 fill-and-stop
        wtm_level = 5'd7;
        set_mode(1'b1, 2'd1);
        chk("R8", "count after mode change", int'(fill_count), 0);
        for (int n = 0; n < DEPTH; n++) begin
            push(n);
            chk("R4", "count while filling", int'(fill_count), n + 1);
            chk("R7", "wtm while filling", int'(wtm), int'(n + 1 >= 7));
        end
        chk("R4", "no overrun at full", int'(overrun), 0);
        for (int t = 0; t < DEPTH; t++) begin
            wtm_level = 5'(t); #1;
            chk("R7", "wtm sweep full", int'(wtm), 1);
        end
        push(32); push(33);
        chk("R4", "count after drop", int'(fill_count), DEPTH);
        chk("R4", "overrun after drop", int'(overrun), 1);
        for (int n = 0; n < DEPTH; n++) read_slot(n, "R3");
        chk("R3", "count after 192 bytes", int'(fill_count), 0);
        for (int t = 0; t < DEPTH; t++) begin
            wtm_level = 5'(t); #1;
            chk("R7", "wtm sweep empty", int'(wtm), int'(t == 0));
        end
        push(34);
        chk("R4", "stopped after drop", int'(fill_count), 0);

        // R5 overwrite
        set_mode(1'b1, 2'd2);
        chk("R8", "overrun cleared", int'(overrun), 0);
        for (int n = 0; n < 40; n++) push(n);
        chk("R5", "count stream", int'(fill_count), DEPTH);
        chk("R5", "overrun stream", int'(overrun), 1);
        for (int n = 8; n < 40; n++) read_slot(n, "R5");

        // R6 overwrite until trigger, then fill-and-stop
        set_mode(1'b1, 2'd3);
        for (int n = 0; n < 40; n++) push(n);
        for (int n = 8; n < 12; n++) read_slot(n, "R6");
        chk("R6", "count before trig", int'(fill_count), 28);
        trig = 1'b1; tick(); trig = 1'b0;
        for (int n = 40; n < 46; n++) push(n);
        chk("R6", "count after trig", int'(fill_count), DEPTH);
        for (int n = 12; n < 44; n++) read_slot(n, "R6");
        chk("R6", "drained", int'(fill_count), 0);
        push(46);
        chk("R6", "stopped after trig fill", int'(fill_count), 0);

        // R9 write and release on the same edge at full
        set_mode(1'b1, 2'd1);
        for (int n = 0; n < DEPTH; n++) push(n);
        for (int b = 0; b < 5; b++) begin
            chk("R9", "slot0 byte", int'(rd_data), int'(exp_byte(0, b)));
            rd_req = 1'b1; tick(); rd_req = 1'b0;
        end
        chk("R9", "slot0 last byte", int'(rd_data), int'(exp_byte(0, 5)));
        rd_req = 1'b1;
        push(32);
        rd_req = 1'b0;
        chk("R9", "count same edge", int'(fill_count), DEPTH);
        chk("R9", "no overrun same edge", int'(overrun), 0);
        for (int n = 1; n <= DEPTH; n++) read_slot(n, "R9");

        // R10 restart without release
        push(50);
        for (int b = 0; b < 3; b++) begin
            rd_req = 1'b1; tick(); rd_req = 1'b0;
        end
        rd_restart = 1'b1; rd_req = 1'b1; tick(); rd_restart = 1'b0; rd_req = 1'b0;
        chk("R10", "count after restart", int'(fill_count), 1);
        read_slot(50, "R10");
        chk("R10", "count after slot", int'(fill_count), 0);

        // R8 disable flushes
        push(60); push(61);
        chk("R8", "count before disable", int'(fill_count), 2);
        fifo_en = 1'b0; tick();
        chk("R8", "count after disable", int'(fill_count), 0);
        chk("R8", "overrun after disable", int'(overrun), 0);
        read_slot(61, "R2");

        report();
    end

endmodule